// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block makes the forwarding decision for transactions seen on the primary side of a bus-to-bus bridge. Configuration software programs three address windows through a simple register write port: an I/O window, a 32-bit memory window and a 64-bit prefetchable memory window. Each window is a base and limit pair, and each pair has coarse granularity. When a transaction is presented with its address and command type, the block reports three results. The first says whether the bridge claims the transaction and forwards it downstream. The second says whether the address fell inside one of the programmed windows. The third is the inverse-of-downstream indication, which an upstream decoder can use.

Several legacy rules sit on top of the window compare. An ISA alias mode stops the bridge from forwarding I/O addresses in the upper three quarters of each 1 KB block within the first 64 KB. A VGA override forwards the legacy display memory and I/O ranges whatever the windows say. A palette snoop claims I/O writes to the three palette registers. The I/O space enable and the memory space enable gate every claim. The result appears one clock after the transaction is presented.

Top module: `bwin_decoder`

## Requirements
- R1: After reset, dec_valid and fwd are 0. Every window register reads 0, except the prefetchable type fields: rd_data[15:12] and rd_data[31:28] of register 3 read 4'b0001.
- R2: The register map is as follows.
  - Register 0: [3:0] is I/O base address bits [15:12]; [7:4] is I/O limit bits [15:12].
  - Register 1: [15:0] is I/O base bits [31:16]; [31:16] is I/O limit bits [31:16].
  - Register 2: [11:0] is memory base bits [31:20]; [27:16] is memory limit bits [31:20].
  - Register 3: [11:0] is prefetchable base bits [31:20]; [27:16] is prefetchable limit bits [31:20].
  - Register 4: prefetchable base bits [63:32].
  - Register 5: prefetchable limit bits [63:32].
  - Other bits and addresses 6 and 7 read 0, and writes to addresses 6 and 7 change nothing.
- R3: An I/O command (txn_cmd 0 = I/O read, 1 = I/O write) hits the I/O window when {base_hi,base_lo,12'h000} <= txn_addr[31:0] <= {lim_hi,lim_lo,12'hFFF}.
- R4: A memory command (2 = memory read, 3 = memory write) hits the memory window when txn_addr[63:32] is 0 and {base,20'h0} <= txn_addr[31:0] <= {limit,20'hFFFFF}.
- R5: A memory command hits the prefetchable window when {base_hi,base_lo,20'h0} <= txn_addr <= {lim_hi,lim_lo,20'hFFFFF}.
- R6: A window whose base is above its limit never produces a hit.
- R7: fwd requires io_en for I/O commands and mem_en for memory commands. win_hit and inv_fwd do not depend on either enable.
- R8: With isa_mode set, an I/O window hit with txn_addr[31:16]==0 and txn_addr[9:8]!=0 is not forwarded, and inv_fwd is 1 for it.
- R9: With vga_en set, memory addresses 0xA0000 to 0xBFFFF are forwarded. I/O addresses with txn_addr[31:16]==0 and txn_addr[9:0] in 0x3B0 to 0x3BB or 0x3C0 to 0x3DF are also forwarded, with bits [15:10] ignored. These claims do not assert win_hit.
- R10: With pal_snoop set, I/O writes with txn_addr[31:16]==0 and txn_addr[9:0] equal to 0x3C6, 0x3C8 or 0x3C9 are forwarded. I/O reads at those addresses are not forwarded by this rule.
- R11: inv_fwd is 1 exactly when none of the window, VGA or palette claim terms holds, before enables are applied. It is never 1 together with fwd.
- R12: fwd, win_hit and inv_fwd are registered. They reflect the transaction of the previous clock, and dec_valid marks them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read index |
| rd_data | output | 32 | Register read data, combinational |
| io_en | input | 1 | I/O space enable |
| mem_en | input | 1 | Memory space enable |
| isa_mode | input | 1 | ISA alias blocking mode |
| vga_en | input | 1 | VGA range override |
| pal_snoop | input | 1 | VGA palette write snoop |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_cmd | input | 2 | 0 I/O read, 1 I/O write, 2 memory read, 3 memory write |
| txn_addr | input | 64 | Transaction address |
| dec_valid | output | 1 | Decision outputs valid |
| fwd | output | 1 | Claim and forward downstream |
| win_hit | output | 1 | Address inside a programmed window of its space |
| inv_fwd | output | 1 | Address outside all downstream claim ranges |

## Verification
The assertions assume that txn_cmd, txn_addr and the five mode inputs are stable and known whenever txn_valid is high. They also assume that register writes and transactions arrive in separate cycles, or at least that a decision taken in the same cycle as a write uses the old window values. The bench drives every input at the falling edge. It issues a register write only while txn_valid is low. It changes the mode inputs only between transactions, so each decision is taken against one settled configuration.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  localparam int ADDR_W   = 64;
  localparam int DATA_W   = 32;
  localparam int REG_AW   = 3;
  localparam int IO_LO_W  = 4;
  localparam int IO_HI_W  = 16;
  localparam int MEM_W    = 12;
  localparam int PF_HI_W  = 32;
  localparam int IO_SPAN  = 32;
  localparam logic [3:0] PF_TYPE = 4'b0001;

  typedef enum logic [1:0] {
    CMD_IO_RD  = 2'd0,
    CMD_IO_WR  = 2'd1,
    CMD_MEM_RD = 2'd2,
    CMD_MEM_WR = 2'd3
  } bwin_cmd_e;

  localparam logic [REG_AW-1:0] RA_IO_LO = 3'd0;
  localparam logic [REG_AW-1:0] RA_IO_HI = 3'd1;
  localparam logic [REG_AW-1:0] RA_MEM   = 3'd2;
  localparam logic [REG_AW-1:0] RA_PF_LO = 3'd3;
  localparam logic [REG_AW-1:0] RA_PF_BH = 3'd4;
  localparam logic [REG_AW-1:0] RA_PF_LH = 3'd5;

  typedef struct packed {
    logic [IO_LO_W-1:0] io_base_lo;
    logic [IO_LO_W-1:0] io_lim_lo;
    logic [IO_HI_W-1:0] io_base_hi;
    logic [IO_HI_W-1:0] io_lim_hi;
    logic [MEM_W-1:0]   mem_base;
    logic [MEM_W-1:0]   mem_lim;
    logic [MEM_W-1:0]   pf_base_lo;
    logic [MEM_W-1:0]   pf_lim_lo;
    logic [PF_HI_W-1:0] pf_base_hi;
    logic [PF_HI_W-1:0] pf_lim_hi;
  } bwin_cfg_t;
endpackage

// File: rtl/bwin_regs.sv
module bwin_regs
  import bwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output bwin_cfg_t         cfg
);
  bwin_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      unique case (wr_addr)
        RA_IO_LO: begin
          cfg_d.io_base_lo = wr_data[3:0];
          cfg_d.io_lim_lo  = wr_data[7:4];
        end
        RA_IO_HI: begin
          cfg_d.io_base_hi = wr_data[15:0];
          cfg_d.io_lim_hi  = wr_data[31:16];
        end
        RA_MEM: begin
          cfg_d.mem_base = wr_data[11:0];
          cfg_d.mem_lim  = wr_data[27:16];
        end
        RA_PF_LO: begin
          cfg_d.pf_base_lo = wr_data[11:0];
          cfg_d.pf_lim_lo  = wr_data[27:16];
        end
        RA_PF_BH: cfg_d.pf_base_hi = wr_data;
        RA_PF_LH: cfg_d.pf_lim_hi  = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      RA_IO_LO: rd_data = {24'h0, cfg_q.io_lim_lo, cfg_q.io_base_lo};
      RA_IO_HI: rd_data = {cfg_q.io_lim_hi, cfg_q.io_base_hi};
      RA_MEM:   rd_data = {4'h0, cfg_q.mem_lim, 4'h0, cfg_q.mem_base};
      RA_PF_LO: rd_data = {PF_TYPE, cfg_q.pf_lim_lo, PF_TYPE, cfg_q.pf_base_lo};
      RA_PF_BH: rd_data = cfg_q.pf_base_hi;
      RA_PF_LH: rd_data = cfg_q.pf_lim_hi;
      default:  rd_data = '0;
    endcase
  end

  assign cfg = cfg_q;

  assert_mem_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_MEM) |=>
      (cfg_q.mem_base == $past(wr_data[11:0]) && cfg_q.mem_lim == $past(wr_data[27:16])));

  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > RA_PF_LH) |=> $stable(cfg_q));
endmodule

// File: rtl/bwin_range.sv
module bwin_range #(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] limit,
  input  logic [W-1:0] addr,
  output logic         hit
);
  logic ge_base, le_lim;
  always_comb begin
    ge_base = (addr >= base);
    le_lim  = (addr <= limit);
    hit     = ge_base && le_lim;
  end
endmodule

// File: rtl/bwin_legacy.sv
module bwin_legacy
  import bwin_pkg::*;
#(
  parameter int NPAL = 3
) (
  input  logic [IO_SPAN-1:0] io_addr,
  input  logic [ADDR_W-1:0]  mem_addr,
  input  logic               is_write,
  input  logic               isa_mode,
  input  logic               vga_en,
  input  logic               pal_snoop,
  output logic               isa_blk,
  output logic               vga_io,
  output logic               vga_mem,
  output logic               pal_hit
);
  localparam logic [9:0] PAL_CODE [NPAL] = '{10'h3C6, 10'h3C8, 10'h3C9};

  logic low64k;
  logic [9:0] lo10;
  logic [NPAL-1:0] pal_m;

  assign low64k = (io_addr[31:16] == 16'h0);
  assign lo10   = io_addr[9:0];

  genvar gi;
  generate
    for (gi = 0; gi < NPAL; gi++) begin : g_pal
      assign pal_m[gi] = (lo10 == PAL_CODE[gi]);
    end
  endgenerate

  always_comb begin
    isa_blk = isa_mode && low64k && (io_addr[9:8] != 2'b00);
    vga_io  = vga_en && low64k &&
              (((lo10 >= 10'h3B0) && (lo10 <= 10'h3BB)) ||
               ((lo10 >= 10'h3C0) && (lo10 <= 10'h3DF)));
    vga_mem = vga_en && (mem_addr[ADDR_W-1:17] == 47'd5);
    pal_hit = pal_snoop && is_write && low64k && (|pal_m);
  end
endmodule

// File: rtl/bwin_decoder.sv
module bwin_decoder
  import bwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        io_en,
  input  logic        mem_en,
  input  logic        isa_mode,
  input  logic        vga_en,
  input  logic        pal_snoop,
  input  logic        txn_valid,
  input  logic [1:0]  txn_cmd,
  input  logic [63:0] txn_addr,
  output logic        dec_valid,
  output logic        fwd,
  output logic        win_hit,
  output logic        inv_fwd
);
  bwin_cfg_t cfg;
  bwin_cmd_e cmd;
  logic is_io, is_wr;
  logic io_win, mem_win, pf_win, mem_lo32;
  logic isa_blk, vga_io, vga_mem, pal_hit;
  logic io_claim, mem_claim;
  logic fwd_d, hit_d, inv_d;
  logic fwd_q, hit_q, inv_q, vld_q;

  assign cmd   = bwin_cmd_e'(txn_cmd);
  assign is_io = (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
  assign is_wr = (cmd == CMD_IO_WR);

  bwin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cfg(cfg)
  );

  bwin_range #(.W(IO_SPAN)) u_io (
    .base ({cfg.io_base_hi, cfg.io_base_lo, 12'h000}),
    .limit({cfg.io_lim_hi,  cfg.io_lim_lo,  12'hFFF}),
    .addr (txn_addr[31:0]),
    .hit  (io_win)
  );

  bwin_range #(.W(32)) u_mem (
    .base ({cfg.mem_base, 20'h00000}),
    .limit({cfg.mem_lim,  20'hFFFFF}),
    .addr (txn_addr[31:0]),
    .hit  (mem_lo32)
  );

  bwin_range #(.W(ADDR_W)) u_pf (
    .base ({cfg.pf_base_hi, cfg.pf_base_lo, 20'h00000}),
    .limit({cfg.pf_lim_hi,  cfg.pf_lim_lo,  20'hFFFFF}),
    .addr (txn_addr),
    .hit  (pf_win)
  );

  assign mem_win = mem_lo32 && (txn_addr[63:32] == 32'h0);

  bwin_legacy u_leg (
    .io_addr(txn_addr[31:0]), .mem_addr(txn_addr), .is_write(is_wr),
    .isa_mode(isa_mode), .vga_en(vga_en), .pal_snoop(pal_snoop),
    .isa_blk(isa_blk), .vga_io(vga_io), .vga_mem(vga_mem), .pal_hit(pal_hit)
  );

  always_comb begin
    io_claim  = (io_win && !isa_blk) || vga_io || pal_hit;
    mem_claim = mem_win || pf_win || vga_mem;
    if (is_io) begin
      fwd_d = io_en && io_claim;
      hit_d = io_win;
      inv_d = !io_claim;
    end else begin
      fwd_d = mem_en && mem_claim;
      hit_d = mem_win || pf_win;
      inv_d = !mem_claim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= txn_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q <= 1'b0;
      hit_q <= 1'b0;
      inv_q <= 1'b0;
    end else if (txn_valid) begin
      fwd_q <= fwd_d;
      hit_q <= hit_d;
      inv_q <= inv_d;
    end
  end

  assign dec_valid = vld_q;
  assign fwd       = fwd_q;
  assign win_hit   = hit_q;
  assign inv_fwd   = inv_q;

  assert_valid_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> dec_valid);
  assert_valid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !dec_valid);
  assert_io_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && (txn_cmd[1] == 1'b0) && !io_en) |=> !fwd);
  assert_mem_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_cmd[1] && !mem_en) |=> !fwd);
  assert_isa_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && (txn_cmd[1] == 1'b0) && isa_mode && !vga_en && !pal_snoop &&
     txn_addr[31:16] == 16'h0 && txn_addr[9:8] != 2'b00) |=> !fwd);
  assert_vga_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_cmd[1] && mem_en && vga_en &&
     txn_addr >= 64'hA0000 && txn_addr <= 64'hBFFFF) |=> fwd);
  assert_fwd_inv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && fwd) |-> !inv_fwd);
endmodule

// File: tb/sim_bwin_decoder.sv
module sim_bwin_decoder;
  logic        clk, rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        io_en, mem_en, isa_mode, vga_en, pal_snoop;
  logic        txn_valid;
  logic [1:0]  txn_cmd;
  logic [63:0] txn_addr;
  logic        dec_valid, fwd, win_hit, inv_fwd;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  bwin_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .io_en(io_en), .mem_en(mem_en),
    .isa_mode(isa_mode), .vga_en(vga_en), .pal_snoop(pal_snoop),
    .txn_valid(txn_valid), .txn_cmd(txn_cmd), .txn_addr(txn_addr),
    .dec_valid(dec_valid), .fwd(fwd), .win_hit(win_hit), .inv_fwd(inv_fwd)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a decision is presented
  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (exp_q.size() == 0) check("R12 unexpected", 32'd1, 32'd0);
      else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {29'd0, fwd, win_hit, inv_fwd}, {29'd0, e});
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    txn_valid = 0; wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  // Driver: expected {fwd, win_hit, inv_fwd}
  task automatic send(input string req, input logic [1:0] c, input logic [63:0] a,
                      input logic [2:0] exp);
    @(negedge clk);
    txn_valid = 1; txn_cmd = c; txn_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    txn_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    io_en = 0; mem_en = 0; isa_mode = 0; vga_en = 0; pal_snoop = 0;
    txn_valid = 0; txn_cmd = 0; txn_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 dec_valid", {31'd0, dec_valid}, 0);
    check("R1 fwd", {31'd0, fwd}, 0);
    rd("R1 io_lo", 3'd0, 0);
    rd("R1 mem", 3'd2, 0);
    rd("R1 pf_lo", 3'd3, 32'h1000_1000);

    wr(3'd0, 32'hFFFF_FF32);
    wr(3'd1, 32'h0000_0000);
    wr(3'd2, 32'hF1FF_F100);
    wr(3'd3, 32'h080F_0800);
    wr(3'd4, 32'h0000_0001);
    wr(3'd5, 32'h0000_0001);
    wr(3'd6, 32'hDEAD_BEEF);
    rd("R2 io_lo", 3'd0, 32'h0000_0032);
    rd("R2 mem", 3'd2, 32'h01FF_0100);
    rd("R2 pf_lo", 3'd3, 32'h180F_1800);
    rd("R2 pf_bh", 3'd4, 32'h1);
    rd("R2 unmapped", 3'd6, 0);

    send("R7 io off", 2'd0, 64'h2000, 3'b010);
    send("R7 mem off", 2'd2, 64'h1000_0000, 3'b010);
    io_en = 1; mem_en = 1;
    send("R3 io base", 2'd0, 64'h2000, 3'b110);
    send("R3 io limit", 2'd1, 64'h3FFF, 3'b110);
    send("R3 io below", 2'd0, 64'h1FFF, 3'b001);
    send("R3 io above", 2'd0, 64'h4000, 3'b001);
    send("R4 mem base", 2'd2, 64'h1000_0000, 3'b110);
    send("R4 mem limit", 2'd3, 64'h1FFF_FFFF, 3'b110);
    send("R4 mem above", 2'd2, 64'h2000_0000, 3'b001);
    send("R4 mem below", 2'd2, 64'h0FFF_FFFF, 3'b001);
    send("R4 mem upper", 2'd2, 64'h1_1000_0000, 3'b001);
    send("R5 pf base", 2'd3, 64'h1_8000_0000, 3'b110);
    send("R5 pf limit", 2'd2, 64'h1_80FF_FFFF, 3'b110);
    send("R5 pf above", 2'd2, 64'h1_8100_0000, 3'b001);
    send("R5 pf low32", 2'd2, 64'h0_8000_0000, 3'b001);

    isa_mode = 1;
    send("R8 isa block", 2'd0, 64'h2100, 3'b011);
    send("R8 isa pass", 2'd0, 64'h2000, 3'b110);
    send("R8 isa pass top", 2'd0, 64'h20FF, 3'b110);
    send("R8 isa block hi", 2'd1, 64'h2300, 3'b011);
    wr(3'd1, 32'h0001_0001);
    send("R8 above 64k", 2'd0, 64'h1_2100, 3'b110);

    wr(3'd2, 32'h0200_0300);
    send("R6 inverted a", 2'd2, 64'h2800_0000, 3'b001);
    send("R6 inverted b", 2'd2, 64'h3000_0000, 3'b001);

    vga_en = 1;
    send("R9 vga mem lo", 2'd2, 64'hA0000, 3'b100);
    send("R9 vga mem hi", 2'd3, 64'hBFFFF, 3'b100);
    send("R9 vga mem out", 2'd2, 64'hC0000, 3'b001);
    send("R9 vga mem below", 2'd2, 64'h9FFFF, 3'b001);
    send("R9 vga io 3B0", 2'd0, 64'h3B0, 3'b100);
    send("R9 vga io 3BB", 2'd0, 64'h3BB, 3'b100);
    send("R9 vga io 3BC", 2'd0, 64'h3BC, 3'b001);
    send("R9 vga io 3DF", 2'd1, 64'h3DF, 3'b100);
    send("R9 vga io alias", 2'd0, 64'h7C0, 3'b100);
    mem_en = 0;
    send("R7 vga gated", 2'd2, 64'hA0000, 3'b000);
    mem_en = 1;
    vga_en = 0;
    send("R10 no snoop", 2'd1, 64'h3C6, 3'b001);

    pal_snoop = 1;
    send("R10 pal 3C6", 2'd1, 64'h3C6, 3'b100);
    send("R10 pal alias", 2'd1, 64'h7C8, 3'b100);
    send("R10 pal 3C9", 2'd1, 64'h3C9, 3'b100);
    send("R10 pal read", 2'd0, 64'h3C6, 3'b001);
    send("R10 pal 3C7", 2'd1, 64'h3C7, 3'b001);
    io_en = 0;
    send("R11 inv no enable", 2'd1, 64'h3C6, 3'b000);

    repeat (3) @(negedge clk);
    check("R12 drained", exp_q.size(), 0);
    check("R12 idle valid", {31'd0, dec_valid}, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule